// File: doc/BRIEF.md
# Shift-and-Accumulate Datapath Unit

This unit takes one 16-bit operand per issue and moves it left by 0 to 15 bit positions into a 32-bit intermediate. Before the shift, the operand is widened to 32 bits. A mode input selects sign extension or zero fill for that widening. The upper half of the intermediate is kept in a product-high register. The lower half is kept in a product-low register and is also added into one of four 16-bit accumulators. The sum is written back into that same accumulator.

The operand is either a memory word presented on the input bus or the current contents of an accumulator. A 16-bit addition produces four status flags: carry, overflow, zero and sign. A memory operand also comes with a side tag bit, which is captured. Each issue completes in one clock. The surrounding sequencer handles instruction decode, operand addressing, pointer updates and repeat control.

Top module: `shacc_unit`

## Requirements
- R1: While `rst_n` is low, every accumulator, `ph_o`, `pl_o`, the four flags and `tag_o` read zero. Issues are accepted from the third rising edge after `rst_n` goes high.
- R2: On an issue, `pl_o` takes bits 15:0 of the widened operand shifted left by `shift_i`, with zeros entering from the right. A shift of 0 leaves the widened operand unchanged.
- R3: On an issue, `ph_o` takes bits 31:16 of that shifted value. With `sext_mode_i`=1, the operand is widened by copying its bit 15 into bits 31:16.
- R4: With `sext_mode_i`=0, bits 31:16 of the widened operand are zero, whatever the value of operand bit 15.
- R5: On an issue, accumulator `dst_sel_i` becomes its old value plus the new `pl_o`, modulo 2^16. The other accumulators keep their values. Accumulator k appears on `acc_o[16k+15:16k]`.
- R6: `flag_cy_o` is the carry out of bit 15 of that addition.
- R7: `flag_ov_o` is 1 when both addends have the same bit 15 and the sum's bit 15 differs from it.
- R8: `flag_z_o` is 1 when the 16-bit sum is zero. `flag_sg_o` equals bit 15 of the sum.
- R9: With `src_is_mem_i`=0, the operand is accumulator `src_sel_i` as it was before the edge. This holds even when that accumulator is also the destination.
- R10: On an issue with `src_is_mem_i`=1, `tag_o` takes `mem_tag_i`. On an issue with `src_is_mem_i`=0, `tag_o` is left unchanged.
- R11: With `issue_i`=0, no output changes, whatever the other inputs do.
- R12: An issue's results are visible right after the edge that samples it. Issues on consecutive edges each take effect and see the results of the issue before them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| issue_i | input | 1 | Execute one operation on this edge |
| src_is_mem_i | input | 1 | 1: operand from `mem_word_i`; 0: operand from an accumulator |
| mem_word_i | input | 16 | Memory operand |
| mem_tag_i | input | 1 | Tag bit that comes with the memory operand |
| src_sel_i | input | 2 | Source accumulator index |
| dst_sel_i | input | 2 | Destination accumulator index |
| shift_i | input | 4 | Left shift amount, 0 to 15 |
| sext_mode_i | input | 1 | 1: sign-extend the operand; 0: zero-fill the operand |
| acc_o | output | 64 | Four accumulators, index k in bits 16k+15:16k |
| ph_o | output | 16 | Product-high register |
| pl_o | output | 16 | Product-low register |
| flag_ov_o | output | 1 | Overflow flag |
| flag_sg_o | output | 1 | Sign flag |
| flag_z_o | output | 1 | Zero flag |
| flag_cy_o | output | 1 | Carry flag |
| tag_o | output | 1 | Captured tag bit |

## Verification
Every result is registered, so a corrupted accumulator, product half or flag shows at the ports right after the edge that wrote it. A stray write to an accumulator that was not selected stays visible in `acc_o` until that accumulator is next written. A wrong accumulator value also spreads: the next issue that reads it as source or destination produces wrong product, sum and flags, so a reference model compared on every clock catches the fault within one cycle of it becoming observable.

// File: rtl/shacc_pkg.sv
package shacc_pkg;

  localparam int unsigned WORD_W  = 16;
  localparam int unsigned ACC_CNT = 4;
  localparam int unsigned SHAMT_W = 4;

  typedef struct packed {
    logic ov;
    logic sg;
    logic z;
    logic cy;
  } shacc_flags_t;

endpackage

// File: rtl/shacc_shifter.sv
module shacc_shifter #(
  parameter int unsigned WORD_W  = shacc_pkg::WORD_W,
  parameter int unsigned SHAMT_W = shacc_pkg::SHAMT_W
) (
  input  logic [WORD_W-1:0]  operand_i,
  input  logic [SHAMT_W-1:0] amount_i,
  input  logic               sext_i,
  output logic [WORD_W-1:0]  high_o,
  output logic [WORD_W-1:0]  low_o
);

  localparam int unsigned WIDE_W = 2 * WORD_W;

  logic [WORD_W-1:0] upper_fill;
  logic [WIDE_W-1:0] widened;
  logic [WIDE_W-1:0] shifted;

  always_comb begin
    upper_fill = sext_i ? {WORD_W{operand_i[WORD_W-1]}} : '0;
    widened    = {upper_fill, operand_i};
    shifted    = widened << amount_i;
    high_o     = shifted[WIDE_W-1:WORD_W];
    low_o      = shifted[WORD_W-1:0];
  end

endmodule

// File: rtl/shacc_adder.sv
module shacc_adder #(
  parameter int unsigned WORD_W = shacc_pkg::WORD_W
) (
  input  logic [WORD_W-1:0]    addend_a_i,
  input  logic [WORD_W-1:0]    addend_b_i,
  output logic [WORD_W-1:0]    sum_o,
  output shacc_pkg::shacc_flags_t flags_o
);

  logic [WORD_W:0] wide_sum;
  logic            same_sign;

  always_comb begin
    wide_sum   = {1'b0, addend_a_i} + {1'b0, addend_b_i};
    sum_o      = wide_sum[WORD_W-1:0];
    same_sign  = (addend_a_i[WORD_W-1] == addend_b_i[WORD_W-1]);
    flags_o.cy = wide_sum[WORD_W];
    flags_o.ov = same_sign && (wide_sum[WORD_W-1] != addend_a_i[WORD_W-1]);
    flags_o.z  = (wide_sum[WORD_W-1:0] == '0);
    flags_o.sg = wide_sum[WORD_W-1];
  end

endmodule

// File: rtl/shacc_accbank.sv
module shacc_accbank #(
  parameter int unsigned WORD_W  = shacc_pkg::WORD_W,
  parameter int unsigned ACC_CNT = shacc_pkg::ACC_CNT,
  localparam int unsigned IDX_W  = $clog2(ACC_CNT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [WORD_W-1:0]         wr_data_i,
  input  logic [IDX_W-1:0]          rd_src_idx_i,
  input  logic [IDX_W-1:0]          rd_dst_idx_i,
  output logic [WORD_W-1:0]         rd_src_o,
  output logic [WORD_W-1:0]         rd_dst_o,
  output logic [ACC_CNT*WORD_W-1:0] flat_o
);

  logic [WORD_W-1:0] acc_q [ACC_CNT];
  logic [WORD_W-1:0] acc_d [ACC_CNT];
  logic [ACC_CNT-1:0] acc_en;

  for (genvar k = 0; k < ACC_CNT; k++) begin : g_acc
    always_comb begin
      acc_en[k] = wr_en_i && (wr_idx_i == IDX_W'(k));
      acc_d[k]  = wr_data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q[k] <= '0;
      end else if (acc_en[k]) begin
        acc_q[k] <= acc_d[k];
      end
    end

    assign flat_o[k*WORD_W +: WORD_W] = acc_q[k];
  end

  assign rd_src_o = acc_q[rd_src_idx_i];
  assign rd_dst_o = acc_q[rd_dst_idx_i];

endmodule

// File: rtl/shacc_unit.sv
module shacc_unit #(
  parameter int unsigned WORD_W  = shacc_pkg::WORD_W,
  parameter int unsigned ACC_CNT = shacc_pkg::ACC_CNT,
  parameter int unsigned SHAMT_W = shacc_pkg::SHAMT_W,
  localparam int unsigned IDX_W  = $clog2(ACC_CNT)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      issue_i,
  input  logic                      src_is_mem_i,
  input  logic [WORD_W-1:0]         mem_word_i,
  input  logic                      mem_tag_i,
  input  logic [IDX_W-1:0]          src_sel_i,
  input  logic [IDX_W-1:0]          dst_sel_i,
  input  logic [SHAMT_W-1:0]        shift_i,
  input  logic                      sext_mode_i,
  output logic [ACC_CNT*WORD_W-1:0] acc_o,
  output logic [WORD_W-1:0]         ph_o,
  output logic [WORD_W-1:0]         pl_o,
  output logic                      flag_ov_o,
  output logic                      flag_sg_o,
  output logic                      flag_z_o,
  output logic                      flag_cy_o,
  output logic                      tag_o
);

  import shacc_pkg::*;

  // reset: asserted at once, released after two clean edges
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_core_n = rst_sync_q[1];

  // operand path
  logic [WORD_W-1:0] src_acc_val;
  logic [WORD_W-1:0] dst_acc_val;
  logic [WORD_W-1:0] operand;
  logic [WORD_W-1:0] prod_hi;
  logic [WORD_W-1:0] prod_lo;
  logic [WORD_W-1:0] acc_sum;
  shacc_flags_t      sum_flags;

  assign operand = src_is_mem_i ? mem_word_i : src_acc_val;

  shacc_shifter #(
    .WORD_W  (WORD_W),
    .SHAMT_W (SHAMT_W)
  ) u_shifter (
    .operand_i (operand),
    .amount_i  (shift_i),
    .sext_i    (sext_mode_i),
    .high_o    (prod_hi),
    .low_o     (prod_lo)
  );

  shacc_adder #(
    .WORD_W (WORD_W)
  ) u_adder (
    .addend_a_i (dst_acc_val),
    .addend_b_i (prod_lo),
    .sum_o      (acc_sum),
    .flags_o    (sum_flags)
  );

  shacc_accbank #(
    .WORD_W  (WORD_W),
    .ACC_CNT (ACC_CNT)
  ) u_accbank (
    .clk          (clk),
    .rst_n        (rst_core_n),
    .wr_en_i      (issue_i),
    .wr_idx_i     (dst_sel_i),
    .wr_data_i    (acc_sum),
    .rd_src_idx_i (src_sel_i),
    .rd_dst_idx_i (dst_sel_i),
    .rd_src_o     (src_acc_val),
    .rd_dst_o     (dst_acc_val),
    .flat_o       (acc_o)
  );

  // product and status registers
  logic [WORD_W-1:0] ph_q, ph_d;
  logic [WORD_W-1:0] pl_q, pl_d;
  shacc_flags_t      flags_q, flags_d;
  logic              tag_q, tag_d;
  logic              prod_en;
  logic              tag_en;

  always_comb begin
    prod_en = issue_i;
    tag_en  = issue_i && src_is_mem_i;
    ph_d    = prod_hi;
    pl_d    = prod_lo;
    flags_d = sum_flags;
    tag_d   = mem_tag_i;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ph_q    <= '0;
      pl_q    <= '0;
      flags_q <= '0;
    end else if (prod_en) begin
      ph_q    <= ph_d;
      pl_q    <= pl_d;
      flags_q <= flags_d;
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      tag_q <= 1'b0;
    end else if (tag_en) begin
      tag_q <= tag_d;
    end
  end

  assign ph_o      = ph_q;
  assign pl_o      = pl_q;
  assign flag_ov_o = flags_q.ov;
  assign flag_sg_o = flags_q.sg;
  assign flag_z_o  = flags_q.z;
  assign flag_cy_o = flags_q.cy;
  assign tag_o     = tag_q;

endmodule

// File: rtl/shacc_checker.sv
module shacc_checker #(
  parameter int unsigned WORD_W  = shacc_pkg::WORD_W,
  parameter int unsigned ACC_CNT = shacc_pkg::ACC_CNT,
  parameter int unsigned SHAMT_W = shacc_pkg::SHAMT_W,
  localparam int unsigned IDX_W  = $clog2(ACC_CNT)
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      issue_i,
  input logic                      src_is_mem_i,
  input logic [WORD_W-1:0]         mem_word_i,
  input logic                      mem_tag_i,
  input logic [IDX_W-1:0]          dst_sel_i,
  input logic [SHAMT_W-1:0]        shift_i,
  input logic                      sext_mode_i,
  input logic [ACC_CNT*WORD_W-1:0] acc_o,
  input logic [WORD_W-1:0]         ph_o,
  input logic [WORD_W-1:0]         pl_o,
  input logic                      flag_ov_o,
  input logic                      flag_sg_o,
  input logic                      flag_z_o,
  input logic                      flag_cy_o,
  input logic                      tag_o
);

  function automatic logic [WORD_W-1:0] pick(input logic [ACC_CNT*WORD_W-1:0] flat,
                                             input logic [IDX_W-1:0] idx);
    return flat[idx*WORD_W +: WORD_W];
  endfunction

  // R1: reset holds everything at zero
  always @(posedge clk) begin
    if (!rst_n) begin
      a_r1_reset_zero: assert (acc_o == '0 && ph_o == '0 && pl_o == '0 &&
                               !flag_ov_o && !flag_sg_o && !flag_z_o &&
                               !flag_cy_o && !tag_o);
    end
  end

  // R2: unshifted memory operand lands whole in the low half
  a_r2_shift_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && src_is_mem_i && shift_i == '0) |=> (pl_o == $past(mem_word_i)));

  // R4: zero-fill mode with no shift leaves the high half empty
  a_r4_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !sext_mode_i && shift_i == '0) |=> (ph_o == '0));

  // R5: unselected accumulators hold
  for (genvar k = 0; k < ACC_CNT; k++) begin : g_hold
    a_r5_others_held: assert property (@(posedge clk) disable iff (!rst_n)
      (issue_i && dst_sel_i != IDX_W'(k)) |=> $stable(acc_o[k*WORD_W +: WORD_W]));
  end

  // R6: carry iff the wrapped sum is below the added low half
  a_r6_carry: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> (flag_cy_o == (pick(acc_o, $past(dst_sel_i)) < pl_o)));

  // R8: zero and sign track the written accumulator
  a_r8_zero_sign: assert property (@(posedge clk) disable iff (!rst_n)
    issue_i |=> (flag_z_o == (pick(acc_o, $past(dst_sel_i)) == '0)) &&
                (flag_sg_o == pick(acc_o, $past(dst_sel_i))[WORD_W-1]));

  // R10: tag follows memory issues and holds otherwise
  a_r10_tag_load: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && src_is_mem_i) |=> (tag_o == $past(mem_tag_i)));
  a_r10_tag_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (issue_i && !src_is_mem_i) |=> $stable(tag_o));

  // R11: idle cycles change nothing
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_i |=> ($stable(acc_o) && $stable(ph_o) && $stable(pl_o) && $stable(tag_o) &&
                  $stable({flag_ov_o, flag_sg_o, flag_z_o, flag_cy_o})));

endmodule

bind shacc_unit shacc_checker #(
  .WORD_W  (WORD_W),
  .ACC_CNT (ACC_CNT),
  .SHAMT_W (SHAMT_W)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .issue_i      (issue_i),
  .src_is_mem_i (src_is_mem_i),
  .mem_word_i   (mem_word_i),
  .mem_tag_i    (mem_tag_i),
  .dst_sel_i    (dst_sel_i),
  .shift_i      (shift_i),
  .sext_mode_i  (sext_mode_i),
  .acc_o        (acc_o),
  .ph_o         (ph_o),
  .pl_o         (pl_o),
  .flag_ov_o    (flag_ov_o),
  .flag_sg_o    (flag_sg_o),
  .flag_z_o     (flag_z_o),
  .flag_cy_o    (flag_cy_o),
  .tag_o        (tag_o)
);

// File: tb/shacc_unit_tb.sv
module shacc_unit_tb;

  logic        clk;
  logic        rst_n;
  logic        issue_i;
  logic        src_is_mem_i;
  logic [15:0] mem_word_i;
  logic        mem_tag_i;
  logic [1:0]  src_sel_i;
  logic [1:0]  dst_sel_i;
  logic [3:0]  shift_i;
  logic        sext_mode_i;
  logic [63:0] acc_o;
  logic [15:0] ph_o;
  logic [15:0] pl_o;
  logic        flag_ov_o, flag_sg_o, flag_z_o, flag_cy_o, tag_o;

  shacc_unit u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .issue_i      (issue_i),
    .src_is_mem_i (src_is_mem_i),
    .mem_word_i   (mem_word_i),
    .mem_tag_i    (mem_tag_i),
    .src_sel_i    (src_sel_i),
    .dst_sel_i    (dst_sel_i),
    .shift_i      (shift_i),
    .sext_mode_i  (sext_mode_i),
    .acc_o        (acc_o),
    .ph_o         (ph_o),
    .pl_o         (pl_o),
    .flag_ov_o    (flag_ov_o),
    .flag_sg_o    (flag_sg_o),
    .flag_z_o     (flag_z_o),
    .flag_cy_o    (flag_cy_o),
    .tag_o        (tag_o)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // behavioural reference state
  int m_acc [4];
  int m_ph, m_pl, m_ov, m_sg, m_z, m_cy, m_tag;

  task automatic model_clear();
    foreach (m_acc[i]) m_acc[i] = 0;
    m_ph = 0; m_pl = 0; m_ov = 0; m_sg = 0; m_z = 0; m_cy = 0; m_tag = 0;
  endtask

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic compare_all(string scen);
    for (int k = 0; k < 4; k++)
      check({scen, "/R5"}, $sformatf("acc%0d", k), int'(acc_o[k*16 +: 16]), m_acc[k]);
    check({scen, "/R3"}, "ph", int'(ph_o), m_ph);
    check({scen, "/R2"}, "pl", int'(pl_o), m_pl);
    check({scen, "/R6"}, "carry", int'(flag_cy_o), m_cy);
    check({scen, "/R7"}, "overflow", int'(flag_ov_o), m_ov);
    check({scen, "/R8"}, "zero", int'(flag_z_o), m_z);
    check({scen, "/R8"}, "sign", int'(flag_sg_o), m_sg);
    check({scen, "/R10"}, "tag", int'(tag_o), m_tag);
  endtask

  // one cycle: drive at the falling edge, model at the rising edge, compare at the next fall
  task automatic step(string scen, bit iss, bit mem, int word, bit tg,
                      int src, int dst, int sh, bit sx);
    int op, wide, lo, sum, old;
    issue_i = iss; src_is_mem_i = mem; mem_word_i = 16'(word); mem_tag_i = tg;
    src_sel_i = 2'(src); dst_sel_i = 2'(dst); shift_i = 4'(sh); sext_mode_i = sx;
    @(posedge clk);
    if (iss) begin
      op   = mem ? (word & 32'hFFFF) : m_acc[src];
      wide = (sx && op >= 32'h8000) ? (op | 32'hFFFF0000) : op;
      wide = wide << sh;
      m_ph = (wide >> 16) & 32'hFFFF;
      lo   = wide & 32'hFFFF;
      old  = m_acc[dst];
      sum  = old + lo;
      m_pl = lo;
      m_cy = (sum >= 32'h10000) ? 1 : 0;
      sum  = sum & 32'hFFFF;
      m_acc[dst] = sum;
      m_z  = (sum == 0) ? 1 : 0;
      m_sg = (sum >= 32'h8000) ? 1 : 0;
      m_ov = (((old >= 32'h8000) == (lo >= 32'h8000)) &&
              ((sum >= 32'h8000) != (old >= 32'h8000))) ? 1 : 0;
      if (mem) m_tag = tg;
    end
    @(negedge clk);
    compare_all(scen);
  endtask

  task automatic do_reset(string scen);
    rst_n = 1'b0;
    issue_i = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    compare_all(scen);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    compare_all(scen);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0;
    issue_i = 1'b0; src_is_mem_i = 1'b0; mem_word_i = '0; mem_tag_i = 1'b0;
    src_sel_i = '0; dst_sel_i = '0; shift_i = '0; sext_mode_i = 1'b0;
    model_clear();
    @(negedge clk);
    do_reset("R1");

    // R2 / R12: every shift amount, back to back, into acc0
    for (int s = 0; s < 16; s++) step("R2", 1, 1, 16'h0001, s[0], 0, 0, s, 0);
    for (int s = 0; s < 16; s++) step("R12", 1, 1, 16'hA5C3, 1, 0, 0, s, 1);

    // R3 / R4: negative operand, sign-extended then zero-filled
    step("R3", 1, 1, 16'h8000, 0, 0, 3, 4, 1);  // ph FFF8, pl 0000
    step("R4", 1, 1, 16'h8000, 0, 0, 3, 4, 0);  // ph 0008, pl 0000
    step("R4", 1, 1, 16'hFFFF, 0, 0, 3, 0, 0);  // ph 0000

    // R6: wrap to zero with carry on acc1
    step("R6", 1, 1, 16'hFFFF, 0, 0, 1, 0, 0);
    step("R6", 1, 1, 16'h0001, 1, 0, 1, 0, 0);

    // R7: positive overflow on acc2
    step("R7", 1, 1, 16'h7FFF, 0, 0, 2, 0, 0);
    step("R7", 1, 1, 16'h0001, 0, 0, 2, 0, 0);

    // R9: accumulator source, same and different destination
    step("R9", 1, 0, 16'h1234, 0, 2, 2, 1, 1);
    step("R9", 1, 0, 16'h0000, 1, 1, 0, 3, 0);

    // R10: memory loads the tag, accumulator source holds it
    step("R10", 1, 1, 16'h0010, 1, 0, 3, 2, 0);
    step("R10", 1, 0, 16'h0000, 0, 3, 3, 2, 0);
    step("R10", 1, 1, 16'h0010, 0, 0, 3, 2, 0);
    step("R10", 1, 0, 16'h0000, 1, 0, 1, 5, 1);

    // R11: idle with noisy inputs
    for (int i = 0; i < 12; i++)
      step("R11", 0, i[0], int'($urandom) & 32'hFFFF, i[1], i % 4, (i + 1) % 4, i, i[2]);

    // R1: reset in mid-run
    do_reset("R1");

    // mixed traffic
    for (int i = 0; i < 600; i++) begin
      int r;
      r = int'($urandom);
      step("MIX", (r % 5) != 0, r[4], int'($urandom) & 32'hFFFF, r[5],
           (r >> 6) & 3, (r >> 8) & 3, (r >> 10) & 15, r[14]);
    end

    done = 1;
    finish_run();
  end

endmodule